// File: doc/BRIEF.md
# Bus Exception Response Sequencer

This block sequences one bus-master transfer for a DMA channel. It watches a 3-bit exception code while its strobes are out, and decides how each attempt ends. An attempt can complete normally on an acknowledge. It can end and be reissued at once while the block keeps mastership. It can end, give the bus away to another master, win the bus back and then repeat. A reserved code makes the block wait with its strobes held until the code clears. Every ending goes through a one-cycle strobe-negation state, so a cycle is never cut off.

An exception code counts only once it has been sampled unchanged on enough consecutive clock edges. The retry code needs fewer edges than the relinquish code. Any change of the code restarts the count. While a nonzero code is present, the acknowledge input is ignored. The transfer descriptor (address, direction and size, treated as one opaque word) is captured at start and reused for every reissue. The completion pulse, which downstream counters use to advance, fires only for a successful attempt.

Top module: `bx_exc_seq`

## Requirements
- R1: A `start` pulse in the idle state raises `strobe_en` on the next cycle, and `bus_desc` then equals the `desc_in` value seen with `start`.
- R2: With `exc_code` = 3'b000 and `dtack` high during a strobed cycle, the next cycle has `strobe_en` low, with `cycle_end` and `xfer_done` each high for exactly one cycle. The block then returns to idle.
- R3: The plain retry code 3'b001 ends the cycle only after it has been sampled on RETRY_HOLD+1 consecutive edges (two with the defaults). An earlier `dtack` does not end the cycle.
- R4: A retry ending gives `cycle_end` together with `retry_pulse`, and no `xfer_done`. `strobe_en` then stays low for GAP_CYCLES cycles and comes back with the same `bus_desc`, while `release_req` and `bus_req` stay low.
- R5: The relinquish code 3'b010 ends the cycle only after it has been sampled on RELQ_HOLD+1 consecutive edges (three with the defaults), whatever `dtack` does.
- R6: After a relinquish ending, `release_req` stays high until `bus_grant` is seen low. `bus_req` then stays high until `bus_grant` is seen high. After that, `strobe_en` returns with the same `bus_desc`.
- R7: A change of `exc_code` before its hold count is reached restarts the count from the new value.
- R8: A reserved code (3'b011 to 3'b111) keeps `strobe_en` high and makes `dtack` have no effect. Once the code returns to 3'b000, a `dtack` completes the cycle normally.
- R9: `strobe_en` never falls without `cycle_end` high in the same cycle, and at most one of `strobe_en`, `cycle_end`, `release_req`, `bus_req` is high at a time.
- R10: During and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| desc_in | input | DW | Transfer descriptor captured with start |
| dtack | input | 1 | Data transfer acknowledge from the slave |
| exc_code | input | 3 | Bus exception code, 000 means none |
| bus_grant | input | 1 | Bus grant from the external arbiter |
| strobe_en | output | 1 | Address/data strobe enable |
| bus_desc | output | DW | Descriptor driven for the current attempt |
| cycle_end | output | 1 | One-cycle pulse in the strobe-negation cycle |
| xfer_done | output | 1 | One-cycle pulse for a successful attempt |
| retry_pulse | output | 1 | One-cycle pulse for a plain-retry ending |
| release_req | output | 1 | Request to give up the bus |
| bus_req | output | 1 | Rearbitration request for the bus |

## Verification
The hardest case to reach is a code that keeps changing inside the hold window. Each change must restart the count, so a cycle that is one edge short of termination has to survive, even with `dtack` asserted. The bench steps the code through retry, relinquish and back to retry on single edges. Only after that does it hold retry long enough, so an attempt that ends early or late shows up as a scoreboard miscompare. The relinquish path is driven by moving `bus_grant` low and high with extra idle cycles in between, which shows that neither request drops before its condition is met.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ACTIVE, S_NEGATE, S_GAP, S_RELEASE, S_REARB
  } bx_state_e;

  typedef enum logic [1:0] {K_OK, K_RETRY, K_RELQ} bx_kind_e;

  localparam logic [2:0] EXC_NONE  = 3'b000;
  localparam logic [2:0] EXC_RETRY = 3'b001;
  localparam logic [2:0] EXC_RELQ  = 3'b010;
endpackage

// File: rtl/bx_hold_meter.sv
module bx_hold_meter
  import bx_pkg::*;
#(
  parameter int RETRY_HOLD = 1,
  parameter int RELQ_HOLD  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       sample,
  input  logic [2:0] code,
  output logic       retry_ok,
  output logic       relq_ok,
  output logic       reserved
);
  localparam int HOLD_MAX = (RETRY_HOLD > RELQ_HOLD) ? RETRY_HOLD : RELQ_HOLD;
  localparam int RUN_MAX  = HOLD_MAX + 1;
  localparam int RW       = $clog2(RUN_MAX + 1);

  logic [2:0]    prev_q;
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_now;

  // edges seen so far with the present code value, this edge included
  always_comb begin
    if (code == prev_q)
      run_now = (run_q == RW'(RUN_MAX)) ? run_q : run_q + RW'(1);
    else
      run_now = RW'(1);
  end

  assign retry_ok = (code == EXC_RETRY) && (run_now >= RW'(RETRY_HOLD + 1));
  assign relq_ok  = (code == EXC_RELQ)  && (run_now >= RW'(RELQ_HOLD + 1));
  assign reserved = (code != EXC_NONE) && (code != EXC_RETRY) && (code != EXC_RELQ);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_q <= EXC_NONE;
      run_q  <= '0;
    end else if (sample) begin
      prev_q <= code;
      run_q  <= run_now;
    end
  end

  // R7: a code that just changed can never be accepted on that edge
  a_r7_restart_on_change: assert property (@(posedge clk) disable iff (rst)
    (sample && $past(sample) && (code != $past(code))) |-> (!retry_ok && !relq_ok));
endmodule

// File: rtl/bx_desc_hold.sv
module bx_desc_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bx_exc_seq.sv
module bx_exc_seq
  import bx_pkg::*;
#(
  parameter int DW         = 16,
  parameter int RETRY_HOLD = 1,
  parameter int RELQ_HOLD  = 2,
  parameter int GAP_CYCLES = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] desc_in,
  input  logic          dtack,
  input  logic [2:0]    exc_code,
  input  logic          bus_grant,
  output logic          strobe_en,
  output logic [DW-1:0] bus_desc,
  output logic          cycle_end,
  output logic          xfer_done,
  output logic          retry_pulse,
  output logic          release_req,
  output logic          bus_req
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  bx_state_e     state_q, state_nxt;
  bx_kind_e      kind_q, kind_nxt;
  logic [GW-1:0] gap_q;
  logic          retry_ok, relq_ok, code_reserved;

  bx_hold_meter #(.RETRY_HOLD(RETRY_HOLD), .RELQ_HOLD(RELQ_HOLD)) u_meter (
    .clk      (clk),
    .rst      (rst),
    .clear    (state_q != S_ACTIVE),
    .sample   (state_q == S_ACTIVE),
    .code     (exc_code),
    .retry_ok (retry_ok),
    .relq_ok  (relq_ok),
    .reserved (code_reserved)
  );

  bx_desc_hold #(.DW(DW)) u_desc (
    .clk  (clk),
    .rst  (rst),
    .load (state_q == S_IDLE && start),
    .d    (desc_in),
    .q    (bus_desc)
  );

  always_comb begin
    state_nxt = state_q;
    kind_nxt  = kind_q;
    unique case (state_q)
      S_IDLE:    if (start) state_nxt = S_ACTIVE;
      S_ACTIVE: begin
        if (retry_ok) begin
          state_nxt = S_NEGATE;
          kind_nxt  = K_RETRY;
        end else if (relq_ok) begin
          state_nxt = S_NEGATE;
          kind_nxt  = K_RELQ;
        end else if (exc_code == EXC_NONE && dtack) begin
          state_nxt = S_NEGATE;
          kind_nxt  = K_OK;
        end
      end
      S_NEGATE: begin
        case (kind_q)
          K_RETRY: state_nxt = S_GAP;
          K_RELQ:  state_nxt = S_RELEASE;
          default: state_nxt = S_IDLE;
        endcase
      end
      S_GAP:     if (gap_q == GW'(GAP_CYCLES - 1)) state_nxt = S_ACTIVE;
      S_RELEASE: if (!bus_grant) state_nxt = S_REARB;
      S_REARB:   if (bus_grant) state_nxt = S_ACTIVE;
      default:   state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      kind_q      <= K_OK;
      gap_q       <= '0;
      strobe_en   <= 1'b0;
      cycle_end   <= 1'b0;
      xfer_done   <= 1'b0;
      retry_pulse <= 1'b0;
      release_req <= 1'b0;
      bus_req     <= 1'b0;
    end else begin
      state_q     <= state_nxt;
      kind_q      <= kind_nxt;
      gap_q       <= (state_q == S_GAP) ? gap_q + GW'(1) : '0;
      strobe_en   <= (state_nxt == S_ACTIVE);
      cycle_end   <= (state_nxt == S_NEGATE);
      xfer_done   <= (state_nxt == S_NEGATE) && (kind_nxt == K_OK);
      retry_pulse <= (state_nxt == S_NEGATE) && (kind_nxt == K_RETRY);
      release_req <= (state_nxt == S_RELEASE);
      bus_req     <= (state_nxt == S_REARB);
    end
  end

  // R2: success only after a clean code with acknowledge
  a_r2_done_needs_clean_ack: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> ($past(dtack) && $past(exc_code) == EXC_NONE));
  // R3: retry code seen on at least two consecutive edges
  a_r3_retry_held: assert property (@(posedge clk) disable iff (rst)
    retry_pulse |-> ($past(exc_code, 1) == EXC_RETRY && $past(exc_code, 2) == EXC_RETRY));
  // R4: a retry ending is not a completion
  a_r4_retry_not_done: assert property (@(posedge clk) disable iff (rst)
    retry_pulse |-> (cycle_end && !xfer_done));
  // R5: relinquish code seen on at least three consecutive edges
  a_r5_relq_held: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && !xfer_done && !retry_pulse) |->
      ($past(exc_code, 1) == EXC_RELQ && $past(exc_code, 2) == EXC_RELQ &&
       $past(exc_code, 3) == EXC_RELQ));
  // R6: release request held until the grant is seen low
  a_r6_release_holds: assert property (@(posedge clk) disable iff (rst)
    (release_req && bus_grant) |=> release_req);
  // R8: reserved code stalls the strobed cycle
  a_r8_reserved_stall: assert property (@(posedge clk) disable iff (rst)
    (strobe_en && exc_code != EXC_NONE && exc_code != EXC_RETRY && exc_code != EXC_RELQ)
      |=> strobe_en);
  // R9: strobes only drop through the negation cycle
  a_r9_fall_via_negate: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_en) |-> cycle_end);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe_en, cycle_end, release_req, bus_req}));
endmodule

// File: tb/test_bx_exc_seq.sv
module test_bx_exc_seq;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] desc_in = '0;
  logic          dtack = 1'b0;
  logic [2:0]    exc_code = 3'b000;
  logic          bus_grant = 1'b1;
  logic          strobe_en, cycle_end, xfer_done, retry_pulse, release_req, bus_req;
  logic [DW-1:0] bus_desc;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  logic [DW+1:0] exp_q[$];

  always #10 clk = ~clk;

  bx_exc_seq #(.DW(DW)) i_bx_exc_seq (
    .clk(clk), .rst(rst), .start(start), .desc_in(desc_in), .dtack(dtack),
    .exc_code(exc_code), .bus_grant(bus_grant), .strobe_en(strobe_en),
    .bus_desc(bus_desc), .cycle_end(cycle_end), .xfer_done(xfer_done),
    .retry_pulse(retry_pulse), .release_req(release_req), .bus_req(bus_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // driver: issue a start and queue the endings this attempt should produce
  task automatic issue(input logic [DW-1:0] d, input int kinds[$]);
    foreach (kinds[i]) exp_q.push_back({kinds[i][1:0], d});
    start = 1'b1; desc_in = d;
    tick();
    start = 1'b0; desc_in = '0;
    chk("R1 strobe after start", strobe_en, 1);
    chk("R1 descriptor captured", bus_desc, d);
  endtask

  // monitor: every cycle ending is compared with the scoreboard
  always @(negedge clk) begin
    if (!rst && cycle_end) begin
      int kind;
      kind = xfer_done ? 0 : (retry_pulse ? 1 : 2);
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected ending actual=%0d expected=none", kind);
      end else begin
        logic [DW+1:0] e;
        e = exp_q.pop_front();
        if ({kind[1:0], bus_desc} != e) begin
          n_bad++;
          $display("FAIL R4 ending kind/desc actual=%0h expected=%0h", {kind[1:0], bus_desc}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R10 strobe in reset", strobe_en, 0);
    chk("R10 requests in reset", {release_req, bus_req, cycle_end}, 0);
    rst = 1'b0;
    tick();
    chk("R10 idle after reset", {strobe_en, cycle_end, xfer_done, retry_pulse, release_req, bus_req}, 0);

    // normal completion
    issue(16'hA001, '{0});
    dtack = 1'b1; tick(); dtack = 1'b0;
    chk("R2 strobe negated", strobe_en, 0);
    chk("R2 end pulse", cycle_end, 1);
    chk("R2 done pulse", xfer_done, 1);
    tick();
    chk("R2 single pulse", {cycle_end, xfer_done, strobe_en}, 0);

    // plain retry, dtack present from the first edge
    issue(16'hB002, '{1, 0});
    exc_code = 3'b001; dtack = 1'b1;
    tick();
    chk("R3 retry not yet held", strobe_en, 1);
    chk("R3 dtack ignored", cycle_end, 0);
    tick();
    exc_code = 3'b000; dtack = 1'b0;
    chk("R4 retry ending", {cycle_end, retry_pulse, xfer_done, strobe_en}, 4'b1100);
    tick();
    chk("R4 bus idle gap", {strobe_en, release_req, bus_req}, 0);
    tick();
    chk("R4 reissue strobe", strobe_en, 1);
    chk("R4 reissue desc", bus_desc, 16'hB002);
    dtack = 1'b1; tick(); dtack = 1'b0;
    chk("R4 retried attempt completes", xfer_done, 1);
    tick();

    // relinquish and retry
    issue(16'hC003, '{2, 0});
    exc_code = 3'b010; dtack = 1'b1;
    tick(); chk("R5 relq edge one", strobe_en, 1);
    tick(); chk("R5 relq edge two", strobe_en, 1);
    tick();
    exc_code = 3'b000; dtack = 1'b0;
    chk("R5 relq ending", {cycle_end, retry_pulse, xfer_done}, 3'b100);
    tick(); chk("R6 release asserted", release_req, 1);
    tick(); tick();
    chk("R6 release held while granted", {release_req, bus_req}, 2'b10);
    bus_grant = 1'b0;
    tick(); chk("R6 rearbitration request", {release_req, bus_req}, 2'b01);
    tick(); tick();
    chk("R6 request held without grant", {bus_req, strobe_en}, 2'b10);
    bus_grant = 1'b1;
    tick();
    chk("R6 reissue after regrant", {strobe_en, bus_req}, 2'b10);
    chk("R6 reissue desc", bus_desc, 16'hC003);
    dtack = 1'b1; tick(); dtack = 1'b0;
    chk("R6 repeated transfer completes", xfer_done, 1);
    tick();

    // restart of the hold count on code changes
    issue(16'hD004, '{1, 0});
    dtack = 1'b1;
    exc_code = 3'b001; tick(); chk("R7 first retry edge", strobe_en, 1);
    exc_code = 3'b010; tick(); chk("R7 switch to relq", strobe_en, 1);
    exc_code = 3'b010; tick(); chk("R7 relq count restarted", strobe_en, 1);
    exc_code = 3'b001; tick(); chk("R7 back to retry", strobe_en, 1);
    tick();
    exc_code = 3'b000; dtack = 1'b0;
    chk("R7 retry after full hold", {cycle_end, retry_pulse}, 2'b11);
    tick(); tick();
    chk("R7 reissued", strobe_en, 1);
    dtack = 1'b1; tick(); dtack = 1'b0;
    chk("R7 completes", xfer_done, 1);
    tick();

    // reserved codes stall
    issue(16'hE005, '{0});
    exc_code = 3'b101; dtack = 1'b1;
    tick(); tick(); tick();
    chk("R8 stalled strobe", strobe_en, 1);
    chk("R8 dtack ignored", cycle_end, 0);
    exc_code = 3'b111;
    tick(); chk("R8 other reserved code", {strobe_en, cycle_end}, 2'b10);
    exc_code = 3'b000;
    tick();
    dtack = 1'b0;
    chk("R8 resumes and completes", {cycle_end, xfer_done}, 2'b11);
    tick();

    chk("R9 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule